// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block runs on the slow real-time clock and controls the sequence of powering the system down and bringing it back up. Software powers the system off by writing the value 1 to the hibernate register. The block then watches an external wakeup pin. The pin must stay asserted for a programmable number of consecutive ticks, which filters out glitches.

When a wakeup qualifies, the block turns the power enable back on. It then keeps the system reset output low for a second programmable number of ticks before it returns to normal running.

Both durations are held only in the upper bits of their registers. The lowest five bits of each written value are dropped, so both counts change in steps of 32 ticks. The block accepts register writes only while it is running normally. Writes that arrive while it is powered off, filtering the pin or stretching the reset have no effect.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset the block is running normally: `pwr_en` is 1 and `sys_rst_n` is 1.
- R2: While running, a write of exactly 32'h1 to offset 8'h20 sets `pwr_en` and `sys_rst_n` to 0 from the next clock edge. A write of any other value to that offset leaves both outputs at 1.
- R3: The wakeup filter register at offset 8'h24 keeps only bits 15:5 of the written value. The filter length is F = bits[15:5] × 32 ticks, with at least 1 tick, so the largest value is 0xFFE0.
- R4: The reset-stretch register at offset 8'h28 keeps only bits 11:5 of the written value. The stretch length is H = bits[11:5] × 32 ticks, with at least 1 tick, so the largest value is 0xFE0.
- R5: The wakeup pin (active high) passes through a two-stage synchronizer. While powered off, `pwr_en` rises at the (2+F)-th clock edge after the pin rises, provided the pin has stayed high throughout.
- R6: If the synchronized pin falls before F consecutive high samples, the filter count returns to zero and the block stays powered off. A pin pulse of F−1 ticks never wakes the block, and a later wakeup needs a full F ticks again.
- R7: After `pwr_en` rises, `sys_rst_n` stays low for exactly H cycles while `pwr_en` stays 1. It then rises, and the block is running again.
- R8: Writes to any register are ignored unless the block is running normally. This covers the powered-off, filtering and reset-stretch phases.
- R9: Whenever `pwr_en` is 0, `sys_rst_n` is 0.
- R10: If the wakeup pin is already high when the hibernate write lands, filtering starts at the next edge, and `pwr_en` stays 0 for exactly F cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time tick clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write value |
| wake_pin | input | 1 | External wakeup pin, active high, asynchronous |
| pwr_en | output | 1 | Power enable for the switched domain |
| sys_rst_n | output | 1 | Active-low reset to the switched domain |

## Verification
Two events can land on the same clock edge: the hibernate write that powers the system off, and a wakeup pin that is already qualifying. The bench raises the pin while the block is still running, lets it pass through the synchronizer, and then issues the hibernate write. It expects the power-off window to last exactly F cycles, with no extra re-arm cycle. A second overlap occurs when register writes arrive while the block is powered off. The bench judges these by whether the wakeup that follows still uses the old filter and stretch lengths. All durations are swept over several filter and stretch settings, and the largest values are also checked.

// File: rtl/hws_pkg.sv
package hws_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_OFF  = 2'd1,
        ST_FILT = 2'd2,
        ST_HOLD = 2'd3
    } hws_state_e;
endpackage

// File: rtl/hws_sync.sv
module hws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hws_regs.sv
module hws_regs #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          CNT_W     = 16,
    parameter int          GRAN_LOG2 = 5,
    parameter int          FILT_HI   = 15,
    parameter int          HOLD_HI   = 11,
    parameter logic [7:0]  OFF_ADDR  = 8'h20,
    parameter logic [7:0]  FILT_ADDR = 8'h24,
    parameter logic [7:0]  HOLD_ADDR = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              accept,
    output logic              off_req,
    output logic [CNT_W-1:0]  filt_ticks,
    output logic [CNT_W-1:0]  hold_ticks
);
    localparam int FILT_FW = FILT_HI - GRAN_LOG2 + 1;
    localparam int HOLD_FW = HOLD_HI - GRAN_LOG2 + 1;

    typedef struct packed {
        logic [FILT_FW-1:0] filt;
        logic [HOLD_FW-1:0] hold;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ok;

    always_comb begin
        cfg_d = cfg_q;
        wr_ok = wr_en && accept;
        if (wr_ok && (wr_addr == ADDR_W'(FILT_ADDR))) cfg_d.filt = wr_data[FILT_HI:GRAN_LOG2];
        if (wr_ok && (wr_addr == ADDR_W'(HOLD_ADDR))) cfg_d.hold = wr_data[HOLD_HI:GRAN_LOG2];
        off_req    = wr_ok && (wr_addr == ADDR_W'(OFF_ADDR)) && (wr_data == DATA_W'(1));
        filt_ticks = CNT_W'({cfg_q.filt, {GRAN_LOG2{1'b0}}});
        hold_ticks = CNT_W'({cfg_q.hold, {GRAN_LOG2{1'b0}}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
    import hws_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off_req,
    input  logic             wake_s,
    input  logic [CNT_W-1:0] filt_ticks,
    input  logic [CNT_W-1:0] hold_ticks,
    output logic             accept,
    output logic             pwr_en,
    output logic             sys_rst_n
);
    typedef struct packed {
        hws_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        seq_d   = seq_q;
        cnt_inc = {1'b0, seq_q.cnt} + 1'b1;
        case (seq_q.state)
            ST_RUN: begin
                seq_d.cnt = '0;
                if (off_req) seq_d.state = ST_OFF;
            end
            ST_OFF: begin
                seq_d.cnt = '0;
                if (wake_s) begin
                    if (filt_ticks <= CNT_W'(1)) begin
                        seq_d.state = ST_HOLD;
                    end else begin
                        seq_d.state = ST_FILT;
                        seq_d.cnt   = CNT_W'(1);
                    end
                end
            end
            ST_FILT: begin
                if (!wake_s) begin
                    seq_d.state = ST_OFF;
                    seq_d.cnt   = '0;
                end else if (cnt_inc >= {1'b0, filt_ticks}) begin
                    seq_d.state = ST_HOLD;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
            default: begin
                if (cnt_inc >= {1'b0, hold_ticks}) begin
                    seq_d.state = ST_RUN;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
        endcase
        accept    = (seq_q.state == ST_RUN);
        pwr_en    = (seq_q.state == ST_RUN) || (seq_q.state == ST_HOLD);
        sys_rst_n = (seq_q.state == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_RUN, cnt: '0};
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          GRAN_LOG2   = 5,
    parameter int          FILT_HI     = 15,
    parameter int          HOLD_HI     = 11,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  OFF_ADDR    = 8'h20,
    parameter logic [7:0]  FILT_ADDR   = 8'h24,
    parameter logic [7:0]  HOLD_ADDR   = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_pin,
    output logic              pwr_en,
    output logic              sys_rst_n
);
    localparam int CNT_W = FILT_HI + 1;

    logic             wake_s;
    logic             accept;
    logic             off_req;
    logic [CNT_W-1:0] filt_ticks;
    logic [CNT_W-1:0] hold_ticks;

    hws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wake_pin),
        .sync_out (wake_s)
    );

    hws_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .GRAN_LOG2(GRAN_LOG2),
        .FILT_HI(FILT_HI), .HOLD_HI(HOLD_HI),
        .OFF_ADDR(OFF_ADDR), .FILT_ADDR(FILT_ADDR), .HOLD_ADDR(HOLD_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .accept     (accept),
        .off_req    (off_req),
        .filt_ticks (filt_ticks),
        .hold_ticks (hold_ticks)
    );

    hws_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_req    (off_req),
        .wake_s     (wake_s),
        .filt_ticks (filt_ticks),
        .hold_ticks (hold_ticks),
        .accept     (accept),
        .pwr_en     (pwr_en),
        .sys_rst_n  (sys_rst_n)
    );
endmodule

// File: rtl/hib_wake_seq_chk.sv
module hib_wake_seq_chk #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          CNT_W    = 16,
    parameter logic [7:0]  OFF_ADDR = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wake_s,
    input logic              pwr_en,
    input logic              sys_rst_n,
    input logic [CNT_W-1:0]  filt_ticks,
    input logic [CNT_W-1:0]  hold_ticks
);
    AST_OFF_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> !sys_rst_n); // R9

    AST_OFF_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(wr_en && (wr_addr == ADDR_W'(OFF_ADDR)) && (wr_data == DATA_W'(1)))); // R2

    AST_POWER_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !sys_rst_n); // R7

    AST_RELEASE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> pwr_en); // R7

    AST_WAKE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> $past(wake_s)); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> ($stable(filt_ticks) && $stable(hold_ticks))); // R8
endmodule

bind hib_wake_seq hib_wake_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .OFF_ADDR(OFF_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wake_s     (wake_s),
    .pwr_en     (pwr_en),
    .sys_rst_n  (sys_rst_n),
    .filt_ticks (filt_ticks),
    .hold_ticks (hold_ticks)
);

// File: tb/tb_hib_wake_seq.sv
`timescale 1ns/1ps
module tb_hib_wake_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wake_pin = 1'b0;
    logic        pwr_en;
    logic        sys_rst_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    hib_wake_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wake_pin(wake_pin), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic wake_measure(output int n, output int h);
        wake_pin = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!pwr_en && n < 70000);
        h = 0;
        while (!sys_rst_n && h < 70000) begin h++; @(negedge clk); end
        wake_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic int ticks_of(input int field);
        return (field == 0) ? 1 : field * 32;
    endfunction

    initial begin
        #3_000_000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n, h, f, hh, off;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pwr_en == 1'b1 && sys_rst_n == 1'b1, "R1", {pwr_en, sys_rst_n}, 3);

        // R2 non-1 value to the power-off offset does nothing
        reg_write(8'h20, 32'h3);
        repeat (3) @(negedge clk);
        check(pwr_en && sys_rst_n, "R2 value 3 ignored", {pwr_en, sys_rst_n}, 3);

        // R3 R4 R5 R7 sweep of filter and stretch fields
        for (int fi = 0; fi < 4; fi++) begin
            for (int hi = 0; hi < 3; hi++) begin
                reg_write(8'h24, fi << 5);
                reg_write(8'h28, hi << 5);
                reg_write(8'h20, 32'h1);
                check(!pwr_en && !sys_rst_n, "R2 R9 power off", {pwr_en, sys_rst_n}, 0);
                wake_measure(n, h);
                f = ticks_of(fi); hh = ticks_of(hi);
                check(n == 2 + f, "R3 R5 wake latency", n, 2 + f);
                check(h == hh, "R4 R7 reset stretch", h, hh);
                check(pwr_en && sys_rst_n, "R7 running", {pwr_en, sys_rst_n}, 3);
            end
        end

        // R3 R4 low and high bits masked off
        reg_write(8'h24, 32'hFFFF_003F);
        reg_write(8'h28, 32'hFFFF_F03F);
        reg_write(8'h20, 32'h1);
        wake_measure(n, h);
        check(n == 2 + 32, "R3 masked filter", n, 34);
        check(h == 32, "R4 masked stretch", h, 32);

        // R6 pulse of F-1 ticks never wakes; later wake needs full F
        reg_write(8'h24, 32'h40);
        reg_write(8'h28, 32'h0);
        reg_write(8'h20, 32'h1);
        wake_pin = 1'b1;
        repeat (63) @(negedge clk);
        wake_pin = 1'b0;
        repeat (10) @(negedge clk);
        check(!pwr_en && !sys_rst_n, "R6 short pulse ignored", pwr_en, 0);
        wake_pin = 1'b1;
        repeat (40) @(negedge clk);
        wake_pin = 1'b0;
        repeat (10) @(negedge clk);
        check(!pwr_en, "R6 second short pulse ignored", pwr_en, 0);
        wake_measure(n, h);
        check(n == 66, "R6 full filter after restart", n, 66);

        // R8 writes while powered off are ignored
        reg_write(8'h24, 32'h20);
        reg_write(8'h28, 32'h40);
        reg_write(8'h20, 32'h1);
        reg_write(8'h24, 32'h0);
        reg_write(8'h28, 32'h60);
        reg_write(8'h20, 32'h1);
        check(!pwr_en, "R8 still off", pwr_en, 0);
        wake_measure(n, h);
        check(n == 34, "R8 filter unchanged", n, 34);
        check(h == 64, "R8 stretch unchanged", h, 64);

        // R10 pin already high when the power-off write lands
        for (int fi = 0; fi < 3; fi++) begin
            reg_write(8'h24, fi << 5);
            reg_write(8'h28, 32'h20);
            wake_pin = 1'b1;
            repeat (4) @(negedge clk);
            reg_write(8'h20, 32'h1);
            off = 0;
            while (!pwr_en && off < 70000) begin off++; @(negedge clk); end
            check(off == ticks_of(fi), "R10 off window", off, ticks_of(fi));
            h = 0;
            while (!sys_rst_n && h < 70000) begin h++; @(negedge clk); end
            check(h == 32, "R10 R7 stretch", h, 32);
            wake_pin = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R3 R4 largest values
        reg_write(8'h24, 32'hFFE0);
        reg_write(8'h28, 32'hFE0);
        reg_write(8'h20, 32'h1);
        wake_measure(n, h);
        check(n == 2 + 65504, "R3 max filter", n, 65506);
        check(h == 4064, "R4 max stretch", h, 4064);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule